// File: doc/BRIEF.md
# Three-Digit Stopwatch with Lap Capture

The block is a decimal seconds counter that keeps its count as three separate BCD digits (ones, tens, hundreds) and runs from 000 to 999 before wrapping. It moves forward by one on each cycle where the one-second enable `tick` is high. It moves only while the `stop` input is low. The live digits leave the block on three registered outputs.

When `stop` rises, counting freezes. On the first clock edge that sees `stop` high, the frozen digit triple is written once into an eight-entry lap memory. The slot is chosen by the externally managed `lap_sel` index. A combinational read port returns the stored triple for any `peek_sel` index. The block has no streaming interface. All pins are plain control and status levels, so no valid/ready handshake and no back-pressure apply.

Top module: `lap_stopwatch`

## Requirements
- R1: A synchronous active-high `rst` clears all three digits to 0. It also clears every lap entry, so each entry reads back as 12'h000.
- R2: On a clock edge with `tick`=1 and `stop`=0, the ones digit goes up by one. On an edge with `tick`=0, none of the digits change.
- R3: On an edge with `stop`=1, no digit changes, whatever the value of `tick`.
- R4: When an advancing edge sees ones = 9, ones becomes 0 and tens goes up by one.
- R5: When an advancing edge sees tens = 9 and ones = 9, both become 0 and hundreds goes up by one.
- R6: When an advancing edge sees 999, the count becomes 000.
- R7: On the first edge that sees `stop`=1 after an edge that saw it low (or after reset), the current digits are written to the entry at `lap_sel`. The entry layout is {hundreds[11:8], tens[7:4], ones[3:0]}.
- R8: On later edges while `stop` stays high, nothing is written, even if `lap_sel` changes. The stored slot and all other slots keep their contents.
- R9: `peek_data` returns the entry addressed by `peek_sel` within the same cycle, with no clock edge between them. Slots never written read 12'h000.
- R10: Each digit output always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second advance enable |
| stop | input | 1 | Pause; its rising edge captures a lap |
| lap_sel | input | 3 | Lap slot written on capture |
| peek_sel | input | 3 | Lap slot read on `peek_data` |
| ones | output | 4 | Live ones digit (BCD) |
| tens | output | 4 | Live tens digit (BCD) |
| hundreds | output | 4 | Live hundreds digit (BCD) |
| peek_data | output | 12 | Stored triple {hundreds, tens, ones} |

## Verification
The bench targets each carry boundary:
- 009 to 010: a broken ones carry would show 00A or stay at 000.
- 099 to 100: a missing two-digit condition would give 0A0 or 190.
- 999 to 000: a broken wrap would give 1000-style garbage or stick at 999.

It holds `stop` high with `tick` still pulsing and moves `lap_sel` to a fresh slot. A design that writes on every high cycle would fill that slot. A design that keeps counting while stopped would drift from the captured value. Lap readback is sampled with no clock edge after `peek_sel` changes, which exposes a read path that is registered when it should be combinational.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/sw_bcd_cell.sv
module sw_bcd_cell
  import sw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic carry_in,
  output bcd_t value,
  output logic carry_out
);
  logic at_top;
  assign at_top    = (value == BCD_TOP);
  assign carry_out = carry_in && at_top;

  always_ff @(posedge clk) begin
    if (rst)           value <= '0;
    else if (carry_in) value <= at_top ? '0 : bcd_t'(value + 1'b1);
  end
endmodule

// File: rtl/sw_counter.sv
module sw_counter
  import sw_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int FLAT_W = NUM_DIGITS * DIGIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [FLAT_W-1:0] digits
);
  logic [NUM_DIGITS:0] chain;
  assign chain[0] = advance;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    bcd_t v;
    sw_bcd_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .carry_in (chain[g]),
      .value    (v),
      .carry_out(chain[g+1])
    );
    assign digits[g*DIGIT_W +: DIGIT_W] = v;
  end

  logic unused_top_carry;
  assign unused_top_carry = chain[NUM_DIGITS];
endmodule

// File: rtl/sw_edge_capture.sv
module sw_edge_capture (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic first_high
);
  logic level_q;
  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end
  assign first_high = level && !level_q;
endmodule

// File: rtl/sw_lap_mem.sv
module sw_lap_mem #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam bit FULL_MAP = (DEPTH >= (1 << IDX_W));

  logic [DATA_W-1:0] slots [DEPTH];
  logic wr_ok, rd_ok;

  if (FULL_MAP) begin : g_full
    assign wr_ok = 1'b1;
    assign rd_ok = 1'b1;
  end else begin : g_part
    assign wr_ok = (int'(wr_idx) < DEPTH);
    assign rd_ok = (int'(rd_idx) < DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (wr_en && wr_ok) begin
      slots[wr_idx] <= wr_data;
    end
  end

  assign rd_data = rd_ok ? slots[rd_idx] : '0;
endmodule

// File: rtl/lap_stopwatch.sv
module lap_stopwatch
  import sw_pkg::*;
#(
  parameter int LAP_DEPTH = 8,
  parameter int LAP_IDX_W = 3,
  localparam int NUM_DIGITS = 3,
  localparam int TRIPLE_W = NUM_DIGITS * DIGIT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 stop,
  input  logic [LAP_IDX_W-1:0] lap_sel,
  input  logic [LAP_IDX_W-1:0] peek_sel,
  output logic [DIGIT_W-1:0]   ones,
  output logic [DIGIT_W-1:0]   tens,
  output logic [DIGIT_W-1:0]   hundreds,
  output logic [TRIPLE_W-1:0]  peek_data
);
  logic [TRIPLE_W-1:0] live;
  logic advance, grab;

  assign advance = tick && !stop;

  sw_counter #(.NUM_DIGITS(NUM_DIGITS)) u_count (
    .clk    (clk),
    .rst    (rst),
    .advance(advance),
    .digits (live)
  );

  sw_edge_capture u_edge (
    .clk       (clk),
    .rst       (rst),
    .level     (stop),
    .first_high(grab)
  );

  sw_lap_mem #(.DEPTH(LAP_DEPTH), .IDX_W(LAP_IDX_W), .DATA_W(TRIPLE_W)) u_laps (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (grab),
    .wr_idx (lap_sel),
    .wr_data(live),
    .rd_idx (peek_sel),
    .rd_data(peek_data)
  );

  assign ones     = live[3:0];
  assign tens     = live[7:4];
  assign hundreds = live[11:8];
endmodule

// File: rtl/sw_checker.sv
module sw_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       stop,
  input logic [3:0] ones,
  input logic [3:0] tens,
  input logic [3:0] hundreds
);
  logic go;
  assign go = tick && !stop;

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ones <= 4'd9) && (tens <= 4'd9) && (hundreds <= 4'd9)); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !stop) |=> $stable({hundreds, tens, ones})); // R2

  AST_HOLD_STOP: assert property (@(posedge clk) disable iff (rst)
    stop |=> $stable({hundreds, tens, ones})); // R3

  AST_ONES_STEP: assert property (@(posedge clk) disable iff (rst)
    (go && ones != 4'd9) |=> (ones == $past(ones) + 4'd1) && $stable({hundreds, tens})); // R2

  AST_TENS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (go && ones == 4'd9 && tens != 4'd9) |=> (ones == 4'd0) && (tens == $past(tens) + 4'd1)); // R4

  AST_HUND_CARRY: assert property (@(posedge clk) disable iff (rst)
    (go && ones == 4'd9 && tens == 4'd9 && hundreds != 4'd9)
      |=> (ones == 4'd0) && (tens == 4'd0) && (hundreds == $past(hundreds) + 4'd1)); // R5

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (go && {hundreds, tens, ones} == 12'h999) |=> ({hundreds, tens, ones} == 12'h000)); // R6
endmodule

bind lap_stopwatch sw_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .stop(stop),
  .ones(ones), .tens(tens), .hundreds(hundreds)
);

// File: tb/sim_lap_stopwatch.sv
module sim_lap_stopwatch;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, stop = 1'b0;
  logic [2:0] lap_sel = '0, peek_sel = '0;
  logic [3:0] ones, tens, hundreds;
  logic [11:0] peek_data;

  int n_chk = 0, n_fail = 0;
  int cnt = 0;
  logic prev_stop = 1'b0;
  logic [11:0] exp_lap [8];
  logic [11:0] q_exp [$];
  string q_tag [$];
  bit finished = 0;

  always #10 clk = ~clk;

  lap_stopwatch u0 (
    .clk(clk), .rst(rst), .tick(tick), .stop(stop), .lap_sel(lap_sel),
    .peek_sel(peek_sel), .ones(ones), .tens(tens), .hundreds(hundreds),
    .peek_data(peek_data)
  );

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a negedge; drives one cycle and pushes the expectation.
  task automatic cyc(logic t, logic s, logic [2:0] sel);
    string tag;
    tick = t; stop = s; lap_sel = sel;
    if (s && !prev_stop) exp_lap[sel] = to_bcd(cnt);
    prev_stop = s;
    if (s)                      tag = "R3";
    else if (!t)                tag = "R2";
    else if (cnt == 999)        tag = "R6";
    else if (cnt % 100 == 99)   tag = "R5";
    else if (cnt % 10 == 9)     tag = "R4";
    else                        tag = "R2";
    if (t && !s) cnt = (cnt + 1) % 1000;
    q_exp.push_back(to_bcd(cnt));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run_to(int target);
    while (cnt != target) cyc(1'b1, 1'b0, 3'd0);
  endtask

  task automatic check_lap(int idx, string tag);
    peek_sel = 3'(idx);
    #1;
    check(tag, peek_data, exp_lap[idx]);
  endtask

  // Monitor: compares live digits after every edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic [11:0] e;
        string tg;
        e = q_exp.pop_front();
        tg = q_tag.pop_front();
        check(tg, {hundreds, tens, ones}, e);
        n_chk++;
        if (ones > 4'd9 || tens > 4'd9 || hundreds > 4'd9) begin
          n_fail++;
          $display("FAIL R10 actual=%h expected=digits<=9", {hundreds, tens, ones});
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_lap[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", {hundreds, tens, ones}, 12'h000);
    for (int i = 0; i < 8; i++) check_lap(i, "R1");
    // R2: idle then advance
    repeat (3) cyc(1'b0, 1'b0, 3'd0);
    repeat (5) cyc(1'b1, 1'b0, 3'd0);
    // R3, R7: stop with tick high captures 005 into slot 2
    cyc(1'b1, 1'b1, 3'd2);
    check_lap(2, "R7");
    // R8: stop held, lap_sel moved, ticks keep coming
    repeat (4) cyc(1'b1, 1'b1, 3'd3);
    check_lap(3, "R8");
    check_lap(2, "R8");
    // R4, R5: carry boundaries
    cyc(1'b1, 1'b0, 3'd0);
    run_to(10);
    run_to(100);
    // second capture into slot 7 at 100
    cyc(1'b0, 1'b1, 3'd7);
    check_lap(7, "R7");
    cyc(1'b0, 1'b0, 3'd0);
    // R9: combinational read, no edge between index changes
    peek_sel = 3'd2; #1; check("R9", peek_data, 12'h005);
    peek_sel = 3'd7; #1; check("R9", peek_data, 12'h100);
    peek_sel = 3'd5; #1; check("R9", peek_data, 12'h000);
    // R6: wrap
    run_to(999);
    cyc(1'b1, 1'b0, 3'd0);
    cyc(1'b1, 1'b0, 3'd0);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule